// File: doc/BRIEF.md
# Subcode Q Frame Capture with Host Read Handshake

This block assembles the Q-channel bits of each subcode block into a frame and checks the frame's CRC. It also tests the frame's address field. A frame that passes is copied into a hold register, and a ready flag goes up. A host then reads the 80 data bits over a single serial line, least significant bit first, clocking each bit with its own read clock. The read clock is asynchronous to the block's clock.

The first read clock edge freezes the hold register, so the data cannot change while a read is under way. The host ends the read with a one-cycle release pulse. The release clears the ready flag and lets the next passing frame be captured. If the host never starts a read, the ready flag drops by itself after a fixed number of clock cycles. In address-free mode the address field is not tested, and the CRC alone decides whether a frame is captured.

The Q input is a valid-only stream. A bit is taken on every cycle in which `q_valid` is high, and the block never stalls the source. A frame that cannot be stored because the register is frozen is dropped, not queued. The host-side pins are plain control and status signals.

Top module: `subq_capture`

## Requirements
- R1: A frame is the first 96 bits accepted after a cycle with `q_valid` and `q_sof` both high. The first of these bits is data bit 0. Bits are taken only while `q_valid` is high. A new `q_sof` restarts the frame. Bits that arrive after the 96th bit and before the next `q_sof` are ignored.
- R2: Bits 80 to 95 carry the check value. It is the bitwise inverse of a 16-bit CRC computed over data bits 0 to 79 in arrival order. The CRC uses generator 0x1021, an all-zero start value and shift-left update. The check value is sent most significant bit first. A frame with any mismatch changes neither `frame_rdy` nor the held data.
- R3: With `addr_free` low, a frame is captured only if its address field equals 1. The address field is data bits 4 to 7, with bit 4 as the most significant bit.
- R4: With `addr_free` high, the address field is ignored and any frame with a correct CRC is captured.
- R5: `frame_rdy` rises on the clock edge that takes the last bit of a passing frame, provided the register is not frozen. Until the first read edge, `sq_dout` shows data bit 0 of that frame.
- R6: Each rising edge of `host_clk` advances the output to the next data bit. The output reflects the edge within three clock cycles. After bit 79 has been passed, `sq_dout` holds at 0.
- R7: The first `host_clk` rising edge while `frame_rdy` is high freezes the hold register. A passing frame that completes while the register is frozen is discarded.
- R8: A one-cycle high on `host_release` drives `frame_rdy` and `sq_dout` low on the next edge and unfreezes the register. Any data not yet read becomes invalid.
- R9: If no read edge arrives, `frame_rdy` stays high for `HOLD_CYCLES` cycles, then falls, and `sq_dout` goes to 0. Once the register is frozen, `frame_rdy` does not time out.
- R10: `host_clk` edges while `frame_rdy` is low have no effect. The output stays 0, and the next passing frame is captured and read from bit 0.
- R11: During reset, `frame_rdy` and `sq_dout` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| q_valid | input | 1 | Q stream bit valid |
| q_bit | input | 1 | Q stream data bit |
| q_sof | input | 1 | Marks the first bit of a subcode block (used with `q_valid`) |
| addr_free | input | 1 | Ignore the address field when high |
| host_clk | input | 1 | Host read clock, asynchronous; a rising edge advances the read |
| host_release | input | 1 | Host release pulse, synchronous to `clk` |
| frame_rdy | output | 1 | A captured frame is available |
| sq_dout | output | 1 | Serial read data, least significant bit first |

## Verification
The assertions assume three things about the inputs. First, the host pulses `host_release` only between frames, never in the cycle that completes one. Second, each level of `host_clk` lasts long enough to pass the synchronizer. Third, no read edge lands in the cycle where a frame is loaded. The bench keeps `host_clk` high and low for four clock cycles per read bit and issues releases only after the last frame bit has been sent. It also starts each read well inside the hold window, except in the run that tests the timeout on purpose.

// File: rtl/subq_pkg.sv
package subq_pkg;
  localparam int CRC_W = 16;

  // one serial step of a left-shifting CRC
  function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] cur,
                                                input logic din,
                                                input logic [CRC_W-1:0] poly);
    logic fb;
    logic [CRC_W-1:0] nxt;
    fb  = cur[CRC_W-1] ^ din;
    nxt = {cur[CRC_W-2:0], 1'b0};
    if (fb) nxt = nxt ^ poly;
    return nxt;
  endfunction
endpackage

// File: rtl/subq_deframer.sv
module subq_deframer
  import subq_pkg::*;
#(
  parameter int               DATA_BITS  = 80,
  parameter logic [CRC_W-1:0] POLY       = 16'h1021,
  parameter int               ADDR_POS   = 4,
  parameter int               ADDR_W     = 4,
  parameter int               ADDR_MATCH = 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic                 in_bit,
  input  logic                 in_sof,
  input  logic                 addr_free,
  output logic                 frame_pass,
  output logic [DATA_BITS-1:0] frame_data
);
  localparam int FRAME_BITS = DATA_BITS + CRC_W;
  localparam int CNT_W      = $clog2(FRAME_BITS + 1);
  localparam logic [CNT_W-1:0] CNT_DONE = CNT_W'(FRAME_BITS);
  localparam logic [CNT_W-1:0] CNT_DATA = CNT_W'(DATA_BITS);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FRAME_BITS - 1);
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

  logic [CNT_W-1:0]     cnt_q, pos;
  logic [DATA_BITS-1:0] data_q, data_d;
  logic [CRC_W-1:0]     crc_q, crc_base, crc_d;
  logic                 bad_q, bad_base, bad_d;
  logic                 accept;
  logic [ADDR_W-1:0]    addr_val;
  logic                 addr_ok;

  always_comb begin
    pos      = in_sof ? '0 : cnt_q;
    crc_base = in_sof ? '0 : crc_q;
    bad_base = in_sof ? 1'b0 : bad_q;
    accept   = in_valid && (pos != CNT_DONE);
    data_d   = data_q;
    crc_d    = crc_base;
    bad_d    = bad_base;
    if (pos < CNT_DATA) begin
      // first bit ends up at index 0 after DATA_BITS shifts
      data_d = {in_bit, data_q[DATA_BITS-1:1]};
      crc_d  = crc_step(crc_base, in_bit, POLY);
    end else begin
      // expected check bit is the inverted remainder MSB
      bad_d = bad_base | (in_bit == crc_base[CRC_W-1]);
      crc_d = {crc_base[CRC_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= CNT_DONE;
      data_q <= '0;
      crc_q  <= '0;
      bad_q  <= 1'b0;
    end else if (accept) begin
      cnt_q  <= pos + CNT_ONE;
      data_q <= data_d;
      crc_q  <= crc_d;
      bad_q  <= bad_d;
    end
  end

  // address field: lowest arriving bit is the most significant
  for (genvar g = 0; g < ADDR_W; g++) begin : g_addr
    assign addr_val[ADDR_W-1-g] = data_q[ADDR_POS+g];
  end

  assign addr_ok    = addr_free || (addr_val == ADDR_W'(ADDR_MATCH));
  assign frame_pass = accept && (pos == CNT_LAST) && !bad_d && addr_ok;
  assign frame_data = data_q;
endmodule

// File: rtl/subq_edge_sync.sv
module subq_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise
);
  logic [STAGES-1:0] chain_q;
  logic              last_q;

  if (STAGES == 1) begin : g_one
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= din;
    end
  end else begin : g_many
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], din};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= 1'b0;
    else        last_q <= chain_q[STAGES-1];
  end

  assign rise = chain_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/subq_readout.sv
module subq_readout #(
  parameter int DATA_BITS   = 80,
  parameter int HOLD_CYCLES = 2800000
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               frame_pass,
  input  logic [DATA_BITS-1:0]               frame_data,
  input  logic                               rd_rise,
  input  logic                               release_i,
  output logic                               frame_rdy,
  output logic                               sq_dout,
  output logic                               locked,
  output logic [DATA_BITS-1:0]               hold_data,
  output logic [$clog2(DATA_BITS+1)-1:0]     rd_ptr
);
  localparam int PTR_W = $clog2(DATA_BITS + 1);
  localparam int TMR_W = $clog2(HOLD_CYCLES + 1);
  localparam logic [PTR_W-1:0] PTR_FULL = PTR_W'(DATA_BITS);
  localparam logic [PTR_W-1:0] PTR_ONE  = PTR_W'(1);
  localparam logic [TMR_W-1:0] TMR_LOAD = TMR_W'(HOLD_CYCLES);
  localparam logic [TMR_W-1:0] TMR_ONE  = TMR_W'(1);

  logic                 held_q, locked_q;
  logic [PTR_W-1:0]     ptr_q;
  logic [TMR_W-1:0]     tmr_q;
  logic [DATA_BITS-1:0] hold_q, shifted;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q   <= 1'b0;
      locked_q <= 1'b0;
      ptr_q    <= '0;
      tmr_q    <= '0;
      hold_q   <= '0;
    end else if (release_i) begin
      held_q   <= 1'b0;
      locked_q <= 1'b0;
      ptr_q    <= '0;
      tmr_q    <= '0;
    end else if (frame_pass && !locked_q) begin
      hold_q   <= frame_data;
      held_q   <= 1'b1;
      ptr_q    <= '0;
      tmr_q    <= TMR_LOAD;
    end else if (held_q && rd_rise) begin
      locked_q <= 1'b1;
      if (ptr_q != PTR_FULL) ptr_q <= ptr_q + PTR_ONE;
    end else if (held_q && !locked_q) begin
      if (tmr_q == TMR_ONE) held_q <= 1'b0;
      tmr_q <= tmr_q - TMR_ONE;
    end
  end

  assign shifted   = hold_q >> ptr_q;
  assign sq_dout   = held_q & shifted[0];
  assign frame_rdy = held_q;
  assign locked    = locked_q;
  assign hold_data = hold_q;
  assign rd_ptr    = ptr_q;
endmodule

// File: rtl/subq_capture.sv
module subq_capture
  import subq_pkg::*;
#(
  parameter int               DATA_BITS   = 80,
  parameter logic [CRC_W-1:0] CRC_POLY    = 16'h1021,
  parameter int               ADDR_POS    = 4,
  parameter int               ADDR_W      = 4,
  parameter int               ADDR_MATCH  = 1,
  parameter int               HOLD_CYCLES = 2800000,
  parameter int               SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic q_valid,
  input  logic q_bit,
  input  logic q_sof,
  input  logic addr_free,
  input  logic host_clk,
  input  logic host_release,
  output logic frame_rdy,
  output logic sq_dout
);
  localparam int PTR_W = $clog2(DATA_BITS + 1);

  logic                 frame_pass_w;
  logic [DATA_BITS-1:0] frame_data_w;
  logic                 rd_rise_w;
  logic                 locked_w;
  logic [DATA_BITS-1:0] hold_w;
  logic [PTR_W-1:0]     ptr_w;

  subq_deframer #(
    .DATA_BITS (DATA_BITS),
    .POLY      (CRC_POLY),
    .ADDR_POS  (ADDR_POS),
    .ADDR_W    (ADDR_W),
    .ADDR_MATCH(ADDR_MATCH)
  ) u_deframer (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (q_valid),
    .in_bit    (q_bit),
    .in_sof    (q_sof),
    .addr_free (addr_free),
    .frame_pass(frame_pass_w),
    .frame_data(frame_data_w)
  );

  subq_edge_sync #(
    .STAGES(SYNC_STAGES)
  ) u_rdsync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (host_clk),
    .rise (rd_rise_w)
  );

  subq_readout #(
    .DATA_BITS  (DATA_BITS),
    .HOLD_CYCLES(HOLD_CYCLES)
  ) u_readout (
    .clk       (clk),
    .rst_n     (rst_n),
    .frame_pass(frame_pass_w),
    .frame_data(frame_data_w),
    .rd_rise   (rd_rise_w),
    .release_i (host_release),
    .frame_rdy (frame_rdy),
    .sq_dout   (sq_dout),
    .locked    (locked_w),
    .hold_data (hold_w),
    .rd_ptr    (ptr_w)
  );
endmodule

// File: rtl/subq_capture_chk.sv
module subq_capture_chk #(
  parameter int DATA_BITS = 80,
  parameter int PW        = $clog2(DATA_BITS + 1)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 host_release,
  input logic                 frame_rdy,
  input logic                 sq_dout,
  input logic                 locked,
  input logic                 frame_pass,
  input logic [DATA_BITS-1:0] hold_data,
  input logic [PW-1:0]        rd_ptr
);
  a_r8_release_clears: assert property (@(posedge clk) disable iff (!rst_n)
    host_release |=> (!frame_rdy && !sq_dout));

  a_r6_quiet_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_rdy |-> !sq_dout);

  a_r7_frozen_data: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && !host_release) |=> $stable(hold_data));

  a_r9_frozen_no_expiry: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && !host_release) |=> frame_rdy);

  a_r5_rise_from_frame: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frame_rdy) |-> $past(frame_pass));

  a_r7_lock_needs_ready: assert property (@(posedge clk) disable iff (!rst_n)
    locked |-> frame_rdy);

  a_r6_ptr_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ptr <= PW'(DATA_BITS));
endmodule

bind subq_capture subq_capture_chk #(.DATA_BITS(DATA_BITS)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .host_release(host_release),
  .frame_rdy   (frame_rdy),
  .sq_dout     (sq_dout),
  .locked      (locked_w),
  .frame_pass  (frame_pass_w),
  .hold_data   (hold_w),
  .rd_ptr      (ptr_w)
);

// File: tb/test_subq_capture.sv
module test_subq_capture;
  localparam int DB   = 80;
  localparam int HOLD = 300;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic q_valid = 1'b0, q_bit = 1'b0, q_sof = 1'b0;
  logic addr_free = 1'b0, host_clk = 1'b0, host_release = 1'b0;
  logic frame_rdy, sq_dout;

  int vectors = 0;
  int misses  = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;

  subq_capture #(.HOLD_CYCLES(HOLD)) i_subq_capture (
    .clk(clk), .rst_n(rst_n), .q_valid(q_valid), .q_bit(q_bit), .q_sof(q_sof),
    .addr_free(addr_free), .host_clk(host_clk), .host_release(host_release),
    .frame_rdy(frame_rdy), .sq_dout(sq_dout)
  );

  task automatic chk(input logic act, input logic exp, input string req, input string what);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] ref_crc(input logic [DB-1:0] d);
    logic [15:0] c = '0;
    for (int i = 0; i < DB; i++) begin
      logic fb = c[15] ^ d[i];
      c = {c[14:0], 1'b0};
      if (fb) c = c ^ 16'h1021;
    end
    return c;
  endfunction

  function automatic logic [DB-1:0] make_frame(input int addr, input int seed);
    logic [DB-1:0] d;
    for (int i = 0; i < DB; i++) d[i] = (((i * 5 + seed * 3 + (i / 3) * seed) % 7) < 3);
    for (int j = 0; j < 4; j++) d[4+j] = 1'((addr >> (3 - j)) & 1);
    return d;
  endfunction

  // mode 0 good, 1 flip a check bit, 2 flip a data bit, 3 no start marker
  task automatic send_frame(input logic [DB-1:0] d, input int mode, input int gap);
    logic [15:0]   c;
    logic [DB+15:0] bits;
    c = ref_crc(d);
    for (int i = 0; i < DB; i++) bits[i] = d[i];
    for (int j = 0; j < 16; j++) bits[DB+j] = ~c[15-j];
    if (mode == 1) bits[DB+15] = ~bits[DB+15];
    if (mode == 2) bits[50] = ~bits[50];
    for (int i = 0; i < DB + 16; i++) begin
      if (gap > 1 && (i % gap) == 1) begin
        q_valid = 1'b0;
        @(negedge clk);
      end
      q_valid = 1'b1;
      q_bit   = bits[i];
      q_sof   = (i == 0) && (mode != 3);
      @(negedge clk);
    end
    q_valid = 1'b0;
    q_sof   = 1'b0;
  endtask

  task automatic read_pulse();
    host_clk = 1'b1;
    repeat (4) @(negedge clk);
    host_clk = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic read_all(input logic [DB-1:0] d, input string req, input int first);
    for (int i = first; i < DB; i++) begin
      chk(sq_dout, d[i], req, $sformatf("read bit %0d", i));
      read_pulse();
    end
    chk(sq_dout, 1'b0, req, "output after last bit");
  endtask

  task automatic release_pulse();
    host_release = 1'b1;
    @(negedge clk);
    host_release = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    logic [DB-1:0] fa, fb;
    repeat (5) @(negedge clk);
    chk(frame_rdy, 1'b0, "R11", "ready in reset");
    chk(sq_dout, 1'b0, "R11", "data in reset");
    rst_n = 1'b1;
    @(negedge clk);
    chk(frame_rdy, 1'b0, "R11", "ready after reset");

    // R3 R4 R5 R6 R8: address sweep under both modes
    for (int af = 0; af < 2; af++) begin
      for (int a = 0; a < 16; a++) begin
        logic ex;
        addr_free = 1'(af);
        fa = make_frame(a, af * 16 + a);
        ex = (af == 1) || (a == 1);
        send_frame(fa, 0, a % 4);
        chk(frame_rdy, ex, af ? "R4" : "R3", $sformatf("ready addr %0d", a));
        if (ex) begin
          chk(sq_dout, fa[0], "R5", "bit 0 before read");
          read_all(fa, "R6", 0);
          chk(frame_rdy, 1'b1, "R7", "ready held while frozen");
        end else begin
          chk(sq_dout, 1'b0, "R3", "no data for rejected addr");
        end
        release_pulse();
        chk(frame_rdy, 1'b0, "R8", "ready after release");
      end
    end
    addr_free = 1'b0;

    // R2: corrupted frames
    fa = make_frame(1, 40);
    send_frame(fa, 1, 0);
    chk(frame_rdy, 1'b0, "R2", "bad check bit");
    send_frame(fa, 2, 0);
    chk(frame_rdy, 1'b0, "R2", "bad data bit");
    chk(sq_dout, 1'b0, "R2", "no data after bad frames");
    send_frame(fa, 0, 0);
    fb = make_frame(1, 41);
    send_frame(fb, 1, 0);
    chk(frame_rdy, 1'b1, "R2", "bad frame keeps ready");
    chk(sq_dout, fa[0], "R2", "bad frame keeps data");
    release_pulse();

    // R7 R9: freeze
    fa = make_frame(1, 50);
    fb = make_frame(1, 51);
    send_frame(fa, 0, 0);
    read_pulse();
    chk(sq_dout, fa[1], "R7", "bit 1 after first edge");
    send_frame(fb, 0, 0);
    chk(sq_dout, fa[1], "R7", "frozen against new frame");
    repeat (HOLD + 50) @(negedge clk);
    chk(frame_rdy, 1'b1, "R9", "frozen ready does not expire");
    read_all(fa, "R7", 1);
    release_pulse();
    send_frame(fb, 0, 0);
    chk(frame_rdy, 1'b1, "R8", "capture after release");
    chk(sq_dout, fb[0], "R8", "new data after release");
    release_pulse();

    // R9: expiry without read
    fa = make_frame(1, 60);
    send_frame(fa, 0, 0);
    repeat (HOLD - 5) @(negedge clk);
    chk(frame_rdy, 1'b1, "R9", "ready before expiry");
    repeat (10) @(negedge clk);
    chk(frame_rdy, 1'b0, "R9", "ready after expiry");
    chk(sq_dout, 1'b0, "R9", "data after expiry");

    // R10: read edges with nothing held
    repeat (3) read_pulse();
    chk(sq_dout, 1'b0, "R10", "idle edges output");
    chk(frame_rdy, 1'b0, "R10", "idle edges ready");
    fa = make_frame(1, 61);
    send_frame(fa, 0, 2);
    chk(frame_rdy, 1'b1, "R10", "capture after idle edges");
    read_all(fa, "R10", 0);
    release_pulse();

    // R8: early release invalidates data
    fa = make_frame(1, 70);
    send_frame(fa, 0, 0);
    for (int i = 0; i < 10; i++) read_pulse();
    chk(sq_dout, fa[10], "R8", "mid read bit");
    release_pulse();
    chk(frame_rdy, 1'b0, "R8", "early release ready");
    chk(sq_dout, 1'b0, "R8", "early release data");
    read_pulse();
    chk(sq_dout, 1'b0, "R8", "edge after early release");

    // R1: restart on start marker, trailing bits ignored
    q_valid = 1'b1;
    for (int i = 0; i < 40; i++) begin
      q_sof = (i == 0);
      q_bit = 1'(i % 3 == 0);
      @(negedge clk);
    end
    q_valid = 1'b0;
    q_sof   = 1'b0;
    fa = make_frame(1, 80);
    send_frame(fa, 0, 3);
    chk(frame_rdy, 1'b1, "R1", "restart then full frame");
    chk(sq_dout, fa[0], "R1", "restart data bit 0");
    release_pulse();
    send_frame(fa, 3, 0);
    chk(frame_rdy, 1'b0, "R1", "frame without start marker");
    chk(sq_dout, 1'b0, "R1", "no data without start marker");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      misses++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end
endmodule